// File: doc/BRIEF.md
# Backup Cell Health Scheduler

This block decides when a backup cell is put under a test load and whether the cell has failed. While the main supply is good, it counts seconds from a one-cycle second strobe and starts a test once per interval. A test also runs after every power-up. During a test the block closes the load switch for a fixed number of seconds and watches a comparator that reports whether the cell is still above its trip point. A low reading at any point in the window raises a warning. The warning is meant for a pad that can only pull low.

The warning is sticky. A later periodic test that passes does not clear it. Only a passing test after a power-up releases it. A loss of supply stops all scheduling at once. A test that is running when the supply drops is abandoned without touching the warning, and after the supply returns the interval starts again from zero. The interval and the window length are parameters, so a short run can use small values.

The supply flag, the recovery pulse and the second strobe are synchronous to `clk`. The comparator flag is asynchronous and goes through a synchronizer inside the block.

Top module: `bkup_cell_monitor`

## Requirements
- R1: After reset, `load_en` is 0 and `warn_pull_low` is 0.
- R2: After `supply_ok` rises, no test starts until a `recovery_done` pulse has been seen. The load then connects in the cycle after the next `sec_tick`.
- R3: The load stays connected for exactly `TEST_SECS` strobes. It disconnects in the cycle after the `TEST_SECS`-th `sec_tick` of the window.
- R4: Periodic tests start `INTERVAL_SECS` strobes apart, counted from the start of one test to the start of the next. No load is applied during the `INTERVAL_SECS - TEST_SECS - 1` strobes that come first after a test ends.
- R5: `cell_ok` is 1 while the cell is above the trip point and 0 while it is below. If the synchronized `cell_ok` is 0 in any cycle of the window, `warn_pull_low` becomes 1 when the window ends. A 0 that is seen only outside a window has no effect.
- R6: A periodic test that passes leaves `warn_pull_low` unchanged. An active warning therefore stays at 1.
- R7: A test after a power-up that passes clears `warn_pull_low` to 0.
- R8: When `supply_ok` is 0, `load_en` is 0 from the next cycle on. Any running test is abandoned and `warn_pull_low` keeps its value. The interval restarts only through the power-up sequence.
- R9: A `recovery_done` pulse has no effect while a power-up test is not pending. In particular, it starts no load while the block is counting the interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sec_tick | input | 1 | One-cycle strobe, once per second |
| supply_ok | input | 1 | 1 while the main supply is above its trip point |
| recovery_done | input | 1 | One-cycle pulse when the post-power-up recovery time has elapsed |
| cell_ok | input | 1 | Asynchronous comparator flag: 1 = cell above trip point |
| load_en | output | 1 | 1 connects the test load to the cell |
| warn_pull_low | output | 1 | 1 turns on the open-drain pull-down of the warning pad (warning active) |

## Verification
`load_en` follows the state register, so a change caused by `sec_tick` or `supply_ok` shows up one cycle after the edge that samples the input. The bench drives inputs on falling edges and reads `load_en` at the next falling edge. `warn_pull_low` is updated on the same edge that closes the window, so the bench reads it together with the `load_en` fall. A comparator low takes two synchronizer cycles to reach the detector. For this reason the bench places its low pulses at least two cycles inside a window, or at least three cycles before the next window starts, and the expected warning comes from a bench function that applies R5 to R7.

// File: rtl/bcm_pkg.sv
package bcm_pkg;

  typedef enum logic [2:0] {
    ST_OFF      = 3'd0,
    ST_WAIT_REC = 3'd1,
    ST_ARM      = 3'd2,
    ST_TEST     = 3'd3,
    ST_IDLE     = 3'd4
  } bcm_state_e;

endpackage

// File: rtl/bcm_sync.sv
module bcm_sync #(
  parameter int unsigned STAGES  = 2,
  parameter bit          RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] stage_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= RST_VAL;
        else        stage_q[0] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[i] <= RST_VAL;
        else        stage_q[i] <= stage_q[i-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/bcm_tick_cnt.sv
module bcm_tick_cnt #(
  parameter int unsigned CNT_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] limit,
  output logic             done
);

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  assign cnt_inc = cnt_q + 1'b1;
  assign done    = tick && (cnt_inc == limit);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (tick) cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/bcm_ctrl.sv
module bcm_ctrl
  import bcm_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic supply_ok,
  input  logic recovery_done,
  input  logic sec_tick,
  input  logic cell_ok_s,
  input  logic cnt_done,
  output logic load_en,
  output logic warn,
  output logic cnt_clr,
  output logic cnt_sel_test
);

  bcm_state_e state_q, state_d;
  logic       fail_q, fail_d;
  logic       pwrup_q, pwrup_d;
  logic       warn_q, warn_d;

  always_comb begin
    state_d = state_q;
    fail_d  = fail_q;
    pwrup_d = pwrup_q;
    warn_d  = warn_q;
    if (!supply_ok) begin
      state_d = ST_OFF;
      fail_d  = 1'b0;
    end else begin
      unique case (state_q)
        ST_OFF:      state_d = ST_WAIT_REC;
        ST_WAIT_REC: if (recovery_done) state_d = ST_ARM;
        ST_ARM: begin
          if (sec_tick) begin
            state_d = ST_TEST;
            pwrup_d = 1'b1;
            fail_d  = 1'b0;
          end
        end
        ST_TEST: begin
          if (!cell_ok_s) fail_d = 1'b1;
          if (cnt_done) begin
            state_d = ST_IDLE;
            if (fail_q || !cell_ok_s) warn_d = 1'b1;
            else if (pwrup_q)         warn_d = 1'b0;
          end
        end
        ST_IDLE: begin
          if (cnt_done) begin
            state_d = ST_TEST;
            pwrup_d = 1'b0;
            fail_d  = 1'b0;
          end
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      fail_q  <= 1'b0;
      pwrup_q <= 1'b0;
      warn_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      fail_q  <= fail_d;
      pwrup_q <= pwrup_d;
      warn_q  <= warn_d;
    end
  end

  assign load_en      = (state_q == ST_TEST);
  assign warn         = warn_q;
  assign cnt_sel_test = (state_q == ST_TEST);
  assign cnt_clr      = (state_d != state_q) ||
                        !((state_q == ST_TEST) || (state_q == ST_IDLE));

endmodule

// File: rtl/bkup_cell_monitor.sv
module bkup_cell_monitor #(
  parameter int unsigned INTERVAL_SECS = 86400,
  parameter int unsigned TEST_SECS     = 1,
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sec_tick,
  input  logic supply_ok,
  input  logic recovery_done,
  input  logic cell_ok,
  output logic load_en,
  output logic warn_pull_low
);

  localparam int unsigned IDLE_TICKS = INTERVAL_SECS - TEST_SECS;
  localparam int unsigned CNT_W      = $clog2(INTERVAL_SECS + 1);

  logic             rst_n_sync;
  logic             cell_ok_s;
  logic             cnt_clr, cnt_sel_test, cnt_done;
  logic [CNT_W-1:0] cnt_limit;

  bcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rst_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (1'b1),
    .q     (rst_n_sync)
  );

  bcm_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_cell_sync (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .d     (cell_ok),
    .q     (cell_ok_s)
  );

  assign cnt_limit = cnt_sel_test ? CNT_W'(TEST_SECS) : CNT_W'(IDLE_TICKS);

  bcm_tick_cnt #(.CNT_W(CNT_W)) u_tick_cnt (
    .clk   (clk),
    .rst_n (rst_n_sync),
    .clr   (cnt_clr),
    .tick  (sec_tick),
    .limit (cnt_limit),
    .done  (cnt_done)
  );

  bcm_ctrl u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n_sync),
    .supply_ok     (supply_ok),
    .recovery_done (recovery_done),
    .sec_tick      (sec_tick),
    .cell_ok_s     (cell_ok_s),
    .cnt_done      (cnt_done),
    .load_en       (load_en),
    .warn          (warn_pull_low),
    .cnt_clr       (cnt_clr),
    .cnt_sel_test  (cnt_sel_test)
  );

endmodule

// File: rtl/bcm_checker.sv
module bcm_checker (
  input logic clk,
  input logic rst_n,
  input logic sec_tick,
  input logic supply_ok,
  input logic load_en,
  input logic warn
);

  assert_load_off_nopower_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !supply_ok |=> !load_en);

  assert_load_start_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_en) |-> ($past(sec_tick) && $past(supply_ok)));

  assert_load_end_cause_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(load_en) |-> ($past(sec_tick) || !$past(supply_ok)));

  assert_warn_only_at_window_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(warn) |-> $fell(load_en));

  assert_abort_keeps_warn_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(load_en) && !$past(supply_ok)) |-> $stable(warn));

endmodule

bind bkup_cell_monitor bcm_checker u_bcm_checker (
  .clk       (clk),
  .rst_n     (rst_n_sync),
  .sec_tick  (sec_tick),
  .supply_ok (supply_ok),
  .load_en   (load_en),
  .warn      (warn_pull_low)
);

// File: tb/bkup_cell_monitor_bench.sv
`timescale 1ns/1ps
module bkup_cell_monitor_bench;

  localparam int unsigned INTERVAL_SECS = 6;
  localparam int unsigned TEST_SECS     = 2;
  localparam int unsigned IDLE_TICKS    = INTERVAL_SECS - TEST_SECS;
  localparam int unsigned GAP           = 8;
  localparam int unsigned WD_CYCLES     = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic supply_ok = 1'b0;
  logic recovery_done = 1'b0;
  logic cell_ok = 1'b1;
  logic load_en, warn_pull_low;

  int checks = 0;
  int failures = 0;
  bit exp_warn = 1'b0;

  always #4 clk = ~clk;

  bkup_cell_monitor #(
    .INTERVAL_SECS (INTERVAL_SECS),
    .TEST_SECS     (TEST_SECS),
    .SYNC_STAGES   (2)
  ) u_bkup_cell_monitor (
    .clk           (clk),
    .rst_n         (rst_n),
    .sec_tick      (sec_tick),
    .supply_ok     (supply_ok),
    .recovery_done (recovery_done),
    .cell_ok       (cell_ok),
    .load_en       (load_en),
    .warn_pull_low (warn_pull_low)
  );

  function automatic bit next_warn(bit cur, bit failed, bit pwrup);
    if (failed) return 1'b1;
    if (pwrup)  return 1'b0;
    return cur;
  endfunction

  task automatic chk(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick();
    sec_tick = 1'b1;
    step(1);
    sec_tick = 1'b0;
  endtask

  // One test window, starting with the tick that opens it.
  task automatic run_test(input bit fail, input bit pwrup, input string start_req);
    tick();
    chk(start_req, load_en, 1'b1, "load connects on start tick");
    step(2);
    if (fail) begin
      cell_ok = 1'b0;
      step(3);
      cell_ok = 1'b1;
      step(GAP - 5);
    end else begin
      step(GAP - 2);
    end
    for (int k = 1; k <= int'(TEST_SECS); k++) begin
      tick();
      if (k < int'(TEST_SECS)) chk("R3", load_en, 1'b1, "load held inside window");
      else                     chk("R3", load_en, 1'b0, "load released after last window tick");
      step(GAP);
    end
    exp_warn = next_warn(exp_warn, fail, pwrup);
    chk(fail ? "R5" : (pwrup ? "R7" : "R6"), warn_pull_low, exp_warn, "warning after window");
  endtask

  task automatic idle_phase(input bit low_outside, input bit rec_pulse);
    for (int k = 0; k < int'(IDLE_TICKS) - 1; k++) begin
      tick();
      chk("R4", load_en, 1'b0, "no load before interval ends");
      if (low_outside && k == 0) begin
        cell_ok = 1'b0;
        step(3);
        cell_ok = 1'b1;
        step(GAP - 3);
      end else if (rec_pulse && k == 1) begin
        recovery_done = 1'b1;
        step(1);
        recovery_done = 1'b0;
        chk("R9", load_en, 1'b0, "recovery pulse while counting starts nothing");
        step(GAP - 1);
      end else begin
        step(GAP);
      end
    end
    if (low_outside)
      chk("R5", warn_pull_low, exp_warn, "low reading outside window ignored");
  endtask

  task automatic periodic(input bit fail, input bit low_outside, input bit rec_pulse);
    idle_phase(low_outside, rec_pulse);
    run_test(fail, 1'b0, "R4");
  endtask

  task automatic power_up(input bit fail);
    supply_ok = 1'b1;
    step(3);
    tick();
    chk("R2", load_en, 1'b0, "no test before recovery pulse");
    step(GAP);
    recovery_done = 1'b1;
    step(1);
    recovery_done = 1'b0;
    chk("R2", load_en, 1'b0, "recovery pulse alone does not connect load");
    step(2);
    run_test(fail, 1'b1, "R2");
  endtask

  task automatic power_cycle(input bit fail);
    supply_ok = 1'b0;
    step(1);
    chk("R8", load_en, 1'b0, "no load without supply");
    chk("R8", warn_pull_low, exp_warn, "warning kept through power loss");
    step(3);
    power_up(fail);
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    step(4);
    rst_n = 1'b1;
    step(4);
    chk("R1", load_en, 1'b0, "load after reset");
    chk("R1", warn_pull_low, 1'b0, "warning after reset");

    power_up(1'b0);                    // R2 power-up test, pass
    periodic(1'b0, 1'b1, 1'b1);        // R5 low outside window, R9 stray recovery
    periodic(1'b1, 1'b0, 1'b0);        // R5 fail sets warning
    periodic(1'b0, 1'b0, 1'b0);        // R6 sticky through periodic pass
    power_cycle(1'b0);                 // R7 power-up pass clears

    // R8: power loss in the middle of a failing window
    idle_phase(1'b0, 1'b0);
    tick();
    chk("R4", load_en, 1'b1, "periodic window opens");
    cell_ok = 1'b0;
    step(4);
    supply_ok = 1'b0;
    step(1);
    chk("R8", load_en, 1'b0, "window abandoned on power loss");
    chk("R8", warn_pull_low, exp_warn, "abandoned window leaves warning");
    cell_ok = 1'b1;
    step(4);
    power_up(1'b0);
    periodic(1'b0, 1'b0, 1'b0);        // R8 interval counted afresh

    for (int r = 0; r < 40; r++) begin
      int unsigned act = $urandom_range(0, 2);
      bit fail = 1'($urandom_range(0, 1));
      if (act == 2) power_cycle(fail);
      else          periodic(fail, 1'($urandom_range(0, 1)), 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule